// File: doc/BRIEF.md
# Posted-Write Register Bridge Between Two Clock Domains

This block connects a register bus running on a fast interface clock to a small register file running on a slow functional clock. The functional domain holds the timer registers: run/mode control, counter, reload value, reload trigger and compare value. The bus domain holds the identification word, the interface control bits, the reset status, the pending-bit register and an interrupt-enable register. Bus-domain registers are read and written in the same cycle.

Each functional register has its own toggle handshake. A write places the value in a bus-side holding register, flips a request toggle and raises that register's pending bit. The functional domain synchronises the toggle, applies the value and returns an acknowledge toggle through two flops, and the acknowledge clears the pending bit. In posted mode a write finishes at once. A second write to a register that is still pending is discarded, and a read of a pending register ends with an error. In non-posted mode the bus ready line stays low until the value has been applied.

Counter reads use their own handshake. The functional domain latches the counter into a capture register, and the bus side reads the capture register only after the acknowledge has come back. A soft reset clears the functional registers, and a reset-done bit shows when that has completed.

Top module: `pwb_bridge`

## Requirements
- R1: After reset, address 0 reads the ID_VALUE parameter, address 1 (interface control) reads bit 2 = 1 (posted mode), address 2 (system status) reads bit 0 = 1, and address 3 (pending register) reads 0.
- R2: In posted mode a write to a functional register finishes in the cycle it is presented. That register's pending bit then reads 1. The functional registers are at addresses 8 to 12, and their pending bits are bit 0 control, bit 1 counter, bit 2 reload value, bit 3 trigger and bit 4 compare.
- R3: A pending bit clears only after its value has been applied in the functional domain. From then on the matching fn_* output holds the written value.
- R4: In posted mode a write to a register whose pending bit is set is discarded. The earlier value is the one applied and read back.
- R5: In posted mode a read of a register whose pending bit is set finishes at once with bus_err = 1.
- R6: In non-posted mode (interface control bit 2 = 0) a write to a functional register holds bus_ready low until the value has been applied. When the write completes, its pending bit reads 0 and the fn_* output holds the value.
- R7: A counter read with no write pending stalls for the read handshake. It returns the counter value from the functional domain.
- R8: Any write to the trigger address (11) copies the applied reload value into the counter.
- R9: Writing 1 to interface control bit 1 starts a soft reset. System status bit 0 reads 0 until the functional registers have been cleared and reads 1 afterwards. The soft reset also restores posted mode, clears the interrupt-enable register and clears the read-back copies.
- R10: Interface control and the interrupt-enable register (address 4) take a write at once. They have no pending bit and never stall.
- R11: A read of control, reload value or compare returns the last write that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Interface (bus) clock |
| fclk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| bus_sel | input | 1 | Transfer request, held until bus_ready |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | DW | Write data |
| bus_ready | output | 1 | The transfer completes in the cycle where bus_sel and bus_ready are both high |
| bus_rdata | output | DW | Read data, valid with bus_ready |
| bus_err | output | 1 | Error response, valid with bus_ready |
| fn_ctrl | output | DW | Applied control register |
| fn_count | output | DW | Applied counter register |
| fn_load | output | DW | Applied reload register |
| fn_match | output | DW | Applied compare register |

## Verification
- **Bus-domain results.** Direct-register results, posted-write completions and error responses are combinational, so they are due in the cycle a request is presented. The bench drives requests just after the falling edge of bclk and samples bus_ready, bus_rdata and bus_err one time unit later, before the next rising edge.
- **Handshake results.** Clearing of pending bits, non-posted completions, counter reads and reset-done need two functional-clock edges, one update edge and two bus-clock edges. The bench does not assume a fixed delay for these. It polls the pending or status register, or counts the cycles in which bus_ready stays low.
- **fn_* outputs.** These are checked only after the handshake has reported completion, when they have stopped changing.
- **Posted-mode pending window.** Checks that depend on a bit still being pending are issued within about six bus cycles of the write. The crossing cannot finish that soon because the functional clock is 6.5 times slower.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int NREG = 5;
  localparam int IDX_CTRL  = 0;
  localparam int IDX_CNT   = 1;
  localparam int IDX_LOAD  = 2;
  localparam int IDX_TRIG  = 3;
  localparam int IDX_MATCH = 4;

  localparam logic [3:0] A_ID    = 4'd0;
  localparam logic [3:0] A_IFC   = 4'd1;
  localparam logic [3:0] A_SSTAT = 4'd2;
  localparam logic [3:0] A_PEND  = 4'd3;
  localparam logic [3:0] A_IRQEN = 4'd4;

  localparam int IFC_SRST   = 1;
  localparam int IFC_POSTED = 2;

  typedef enum logic [1:0] {S_IDLE, S_WWAIT, S_RWAIT} bus_st_t;
endpackage

// File: rtl/pwb_rst_sync.sv
module pwb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q       <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      s1_q       <= 1'b1;
      rst_sync_n <= s1_q;
    end
  end
endmodule

// File: rtl/pwb_hs_chan.sv
module pwb_hs_chan (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic launch,
  output logic busy,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic fire
);
  logic req_q, req_d;
  logic ack_s1_q, ack_s2_q;
  logic rq_s1_q, rq_s2_q, rq_s3_q;

  assign busy  = req_q ^ ack_s2_q;
  assign req_d = req_q ^ (launch & ~busy);
  assign fire  = rq_s2_q ^ rq_s3_q;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      req_q    <= 1'b0;
      ack_s1_q <= 1'b0;
      ack_s2_q <= 1'b0;
    end else begin
      req_q    <= req_d;
      ack_s1_q <= rq_s3_q;
      ack_s2_q <= ack_s1_q;
    end
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      rq_s1_q <= 1'b0;
      rq_s2_q <= 1'b0;
      rq_s3_q <= 1'b0;
    end else begin
      rq_s1_q <= req_q;
      rq_s2_q <= rq_s1_q;
      rq_s3_q <= rq_s2_q;
    end
  end

  // R2: an accepted launch raises the busy (pending) flag next cycle
  p_launch_busy_r2: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (launch && !busy) |=> busy);

  // R3: each request is applied exactly once in the destination domain
  p_fire_once_r3: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    fire |=> !fire);
endmodule

// File: rtl/pwb_func_regs.sv
module pwb_func_regs
  import pwb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                     fclk,
  input  logic                     frst_n,
  input  logic [NREG-1:0]          wr_fire,
  input  logic                     sr_fire,
  input  logic                     rd_fire,
  input  logic [NREG-1:0][DW-1:0]  hold,
  output logic [DW-1:0]            ctrl_q,
  output logic [DW-1:0]            cnt_q,
  output logic [DW-1:0]            load_q,
  output logic [DW-1:0]            match_q,
  output logic [DW-1:0]            cap_q
);
  logic [DW-1:0] ctrl_d, cnt_d, load_d, match_d, cap_d;
  logic          unused_trig_data;

  assign unused_trig_data = ^hold[IDX_TRIG];

  always_comb begin
    ctrl_d  = ctrl_q;
    cnt_d   = cnt_q;
    load_d  = load_q;
    match_d = match_q;
    cap_d   = cap_q;
    if (wr_fire[IDX_CTRL])  ctrl_d  = hold[IDX_CTRL];
    if (wr_fire[IDX_CNT])   cnt_d   = hold[IDX_CNT];
    if (wr_fire[IDX_LOAD])  load_d  = hold[IDX_LOAD];
    if (wr_fire[IDX_TRIG])  cnt_d   = load_q;
    if (wr_fire[IDX_MATCH]) match_d = hold[IDX_MATCH];
    if (rd_fire)            cap_d   = cnt_q;
    if (sr_fire) begin
      ctrl_d  = '0;
      cnt_d   = '0;
      load_d  = '0;
      match_d = '0;
    end
  end

  always_ff @(posedge fclk or negedge frst_n) begin
    if (!frst_n) begin
      ctrl_q  <= '0;
      cnt_q   <= '0;
      load_q  <= '0;
      match_q <= '0;
      cap_q   <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      cnt_q   <= cnt_d;
      load_q  <= load_d;
      match_q <= match_d;
      cap_q   <= cap_d;
    end
  end

  // R9: a delivered soft reset leaves every functional register cleared
  p_sreset_clear_r9: assert property (@(posedge fclk) disable iff (!frst_n)
    sr_fire |=> (ctrl_q == '0 && cnt_q == '0 && load_q == '0 && match_q == '0));
endmodule

// File: rtl/pwb_bridge.sv
module pwb_bridge
  import pwb_pkg::*;
#(
  parameter int          DW       = 32,
  parameter logic [31:0] ID_VALUE = 32'h5057_4201
) (
  input  logic          bclk,
  input  logic          fclk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [3:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          bus_ready,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_err,
  output logic [DW-1:0] fn_ctrl,
  output logic [DW-1:0] fn_count,
  output logic [DW-1:0] fn_load,
  output logic [DW-1:0] fn_match
);
  localparam logic [2:0] NREG3 = 3'(NREG);

  logic b_rst_n, f_rst_n;
  bus_st_t state_q, state_d;
  logic [2:0] idx_q, idx_d;
  logic posted_q, posted_d;
  logic [DW-1:0] irqen_q, irqen_d;
  logic [NREG-1:0][DW-1:0] hold_q, hold_d;
  logic [NREG-1:0] launch, pend, wr_fire;
  logic rd_launch, rd_busy, rd_fire;
  logic sr_launch, sr_busy, sr_fire;
  logic [DW-1:0] cap;
  logic [2:0] idx;
  logic is_sync;

  pwb_rst_sync u_brst (.clk(bclk), .rst_n(rst_n), .rst_sync_n(b_rst_n));
  pwb_rst_sync u_frst (.clk(fclk), .rst_n(rst_n), .rst_sync_n(f_rst_n));

  for (genvar i = 0; i < NREG; i++) begin : g_chan
    pwb_hs_chan u_chan (
      .src_clk(bclk), .src_rst_n(b_rst_n), .launch(launch[i]), .busy(pend[i]),
      .dst_clk(fclk), .dst_rst_n(f_rst_n), .fire(wr_fire[i]));

    // R4: a posted write to a pending register leaves its held value untouched
    p_drop_hold_r4: assert property (@(posedge bclk) disable iff (!b_rst_n)
      (state_q == S_IDLE && bus_sel && bus_wr && is_sync && idx == 3'(i)
       && posted_q && pend[i]) |=> $stable(hold_q[i]));
  end

  pwb_hs_chan u_rd_chan (
    .src_clk(bclk), .src_rst_n(b_rst_n), .launch(rd_launch), .busy(rd_busy),
    .dst_clk(fclk), .dst_rst_n(f_rst_n), .fire(rd_fire));

  pwb_hs_chan u_sr_chan (
    .src_clk(bclk), .src_rst_n(b_rst_n), .launch(sr_launch), .busy(sr_busy),
    .dst_clk(fclk), .dst_rst_n(f_rst_n), .fire(sr_fire));

  pwb_func_regs #(.DW(DW)) u_fregs (
    .fclk(fclk), .frst_n(f_rst_n), .wr_fire(wr_fire), .sr_fire(sr_fire),
    .rd_fire(rd_fire), .hold(hold_q), .ctrl_q(fn_ctrl), .cnt_q(fn_count),
    .load_q(fn_load), .match_q(fn_match), .cap_q(cap));

  assign idx     = bus_addr[2:0];
  assign is_sync = bus_addr[3] && (idx < NREG3);

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    posted_d  = posted_q;
    irqen_d   = irqen_q;
    hold_d    = hold_q;
    launch    = '0;
    rd_launch = 1'b0;
    sr_launch = 1'b0;
    bus_ready = 1'b1;
    bus_err   = 1'b0;
    bus_rdata = '0;
    unique case (state_q)
      S_IDLE: if (bus_sel) begin
        if (is_sync) begin
          if (bus_wr) begin
            if (pend[idx]) begin
              bus_ready = posted_q;
            end else begin
              launch[idx] = 1'b1;
              hold_d[idx] = bus_wdata;
              if (!posted_q) begin
                bus_ready = 1'b0;
                state_d   = S_WWAIT;
                idx_d     = idx;
              end
            end
          end else if (pend[idx]) begin
            bus_ready = posted_q;
            bus_err   = posted_q;
          end else if (idx == 3'(IDX_CNT)) begin
            rd_launch = 1'b1;
            bus_ready = 1'b0;
            state_d   = S_RWAIT;
          end else begin
            bus_rdata = hold_q[idx];
          end
        end else if (bus_wr) begin
          if (bus_addr == A_IFC) begin
            posted_d = bus_wdata[IFC_POSTED];
            if (bus_wdata[IFC_SRST] && !sr_busy) begin
              sr_launch = 1'b1;
              posted_d  = 1'b1;
              irqen_d   = '0;
              hold_d    = '0;
            end
          end else if (bus_addr == A_IRQEN) begin
            irqen_d = bus_wdata;
          end
        end else begin
          case (bus_addr)
            A_ID:    bus_rdata = DW'(ID_VALUE);
            A_IFC:   bus_rdata[IFC_POSTED] = posted_q;
            A_SSTAT: bus_rdata[0] = ~sr_busy;
            A_PEND:  bus_rdata[NREG-1:0] = pend;
            A_IRQEN: bus_rdata = irqen_q;
            default: bus_rdata = '0;
          endcase
        end
      end
      S_WWAIT: begin
        bus_ready = ~pend[idx_q];
        if (!pend[idx_q]) state_d = S_IDLE;
      end
      S_RWAIT: begin
        bus_ready = ~rd_busy;
        if (!rd_busy) begin
          bus_rdata = cap;
          state_d   = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge bclk or negedge b_rst_n) begin
    if (!b_rst_n) begin
      state_q  <= S_IDLE;
      idx_q    <= '0;
      posted_q <= 1'b1;
      irqen_q  <= '0;
      hold_q   <= '0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      posted_q <= posted_d;
      irqen_q  <= irqen_d;
      hold_q   <= hold_d;
    end
  end

  // R5: an error response is only given in posted mode and never stalls
  p_err_posted_r5: assert property (@(posedge bclk) disable iff (!b_rst_n)
    bus_err |-> (bus_ready && posted_q));

  // R6: a non-posted write completes only once its crossing has finished
  p_nonposted_done_r6: assert property (@(posedge bclk) disable iff (!b_rst_n)
    (bus_sel && bus_wr && bus_ready && is_sync && !posted_q) |-> !pend[idx]);
endmodule

// File: tb/pwb_bridge_bench.sv
module pwb_bridge_bench;
  localparam logic [31:0] IDV = 32'h5057_4201;
  localparam logic [3:0] A_IFC = 4'd1, A_SSTAT = 4'd2, A_PEND = 4'd3, A_IRQEN = 4'd4;
  localparam logic [3:0] A_CTRL = 4'd8, A_CNT = 4'd9, A_LOAD = 4'd10, A_TRIG = 4'd11, A_MATCH = 4'd12;

  logic bclk = 1'b0, fclk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ready, bus_err;
  logic [31:0] bus_rdata, fn_ctrl, fn_count, fn_load, fn_match;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 bclk = ~bclk;
  always #65 fclk = ~fclk;

  pwb_bridge u_pwb_bridge (
    .bclk(bclk), .fclk(fclk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .fn_ctrl(fn_ctrl),
    .fn_count(fn_count), .fn_load(fn_load), .fn_match(fn_match));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [3:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output logic er, output int waits);
    waits = 0;
    @(negedge bclk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
    while (!bus_ready && waits < 3000) begin
      @(negedge bclk); #1; waits++;
    end
    if (waits >= 3000) check("watchdog", 32'd1, 32'd0);
    rd = bus_rdata; er = bus_err;
    @(posedge bclk);
    @(negedge bclk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  function automatic logic [3:0] ridx_addr(input int k);
    return (k == 0) ? A_CTRL : (k == 1) ? A_LOAD : A_MATCH;
  endfunction

  function automatic logic [31:0] fn_of(input int k, input logic [31:0] c,
                                        input logic [31:0] l, input logic [31:0] m);
    return (k == 0) ? c : (k == 1) ? l : m;
  endfunction

  task automatic wait_idle();
    logic [31:0] r; logic e; int w;
    for (int i = 0; i < 200; i++) begin
      xfer(1'b0, A_PEND, 32'd0, r, e, w);
      if (r == 32'd0) return;
    end
    check("watchdog pend", 32'd1, 32'd0);
  endtask

  initial begin : watchdog
    #(20 * 190000);
    if (!done) begin
      check("watchdog timeout", 32'd1, 32'd0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r; logic e; int w;
    logic [31:0] ed;
    void'($urandom(32'd2024));
    repeat (5) @(negedge bclk);
    rst_n = 1'b1;
    repeat (40) @(negedge bclk);

    xfer(1'b0, 4'd0, 0, r, e, w);    check("R1 id", r, IDV);
    xfer(1'b0, A_IFC, 0, r, e, w);   check("R1 posted default", r, 32'h4);
    xfer(1'b0, A_SSTAT, 0, r, e, w); check("R1 reset done", r, 32'h1);
    xfer(1'b0, A_PEND, 0, r, e, w);  check("R1 pend clear", r, 32'h0);

    xfer(1'b1, A_IRQEN, 32'hA5, r, e, w); check("R10 no stall", w, 0);
    xfer(1'b0, A_PEND, 0, r, e, w);       check("R10 no pend", r, 32'h0);
    xfer(1'b0, A_IRQEN, 0, r, e, w);      check("R10 readback", r, 32'hA5);

    xfer(1'b1, A_LOAD, 32'h1111, r, e, w); check("R2 posted no wait", w, 0);
    xfer(1'b0, A_PEND, 0, r, e, w);        check("R2 pend bit2", r, 32'h4);
    xfer(1'b0, A_LOAD, 0, r, e, w);        check("R5 err on pending read", e, 1);
    xfer(1'b1, A_LOAD, 32'h2222, r, e, w); check("R4 dropped write no wait", w, 0);
    wait_idle();
    check("R3 applied load", fn_load, 32'h1111);
    check("R4 dropped value not applied", fn_load, 32'h1111);
    xfer(1'b0, A_LOAD, 0, r, e, w); check("R11 load readback", r, 32'h1111);
    check("R11 no err", e, 0);

    xfer(1'b1, A_CNT, 32'h77, r, e, w);
    xfer(1'b0, A_CNT, 0, r, e, w); check("R5 counter pending err", e, 1);
    wait_idle();
    xfer(1'b0, A_CNT, 0, r, e, w); check("R7 counter value", r, 32'h77);
    check("R7 read stalled", (w > 0), 1);

    xfer(1'b1, A_IFC, 32'h0, r, e, w);
    xfer(1'b1, A_MATCH, 32'hABC, r, e, w); check("R6 write stalled", (w > 0), 1);
    check("R6 applied at completion", fn_match, 32'hABC);
    xfer(1'b0, A_PEND, 0, r, e, w); check("R6 pend clear", r, 32'h0);

    xfer(1'b1, A_LOAD, 32'h500, r, e, w);
    xfer(1'b1, A_TRIG, 32'hFFFF, r, e, w);
    xfer(1'b0, A_CNT, 0, r, e, w); check("R8 trigger reload", r, 32'h500);
    check("R8 fn counter", fn_count, 32'h500);

    xfer(1'b1, A_CTRL, 32'h3, r, e, w); check("R6 ctrl applied", fn_ctrl, 32'h3);
    xfer(1'b1, A_IFC, 32'h2, r, e, w);
    xfer(1'b0, A_SSTAT, 0, r, e, w); check("R9 reset in progress", r, 32'h0);
    for (int i = 0; i < 200; i++) begin
      xfer(1'b0, A_SSTAT, 0, r, e, w);
      if (r[0]) break;
    end
    check("R9 reset done", r, 32'h1);
    check("R9 ctrl cleared", fn_ctrl, 32'h0);
    check("R9 load cleared", fn_load, 32'h0);
    check("R9 count cleared", fn_count, 32'h0);
    xfer(1'b0, A_IFC, 0, r, e, w);   check("R9 posted restored", r, 32'h4);
    xfer(1'b0, A_IRQEN, 0, r, e, w); check("R9 irqen cleared", r, 32'h0);
    xfer(1'b0, A_MATCH, 0, r, e, w); check("R9 copy cleared", r, 32'h0);

    for (int it = 0; it < 30; it++) begin
      int k; bit pm;
      k = int'($urandom % 3);
      pm = 1'($urandom % 2);
      ed = $urandom;
      xfer(1'b1, A_IFC, pm ? 32'h4 : 32'h0, r, e, w);
      xfer(1'b1, ridx_addr(k), ed, r, e, w);
      if (pm) wait_idle();
      check("R3 random applied", fn_of(k, fn_ctrl, fn_load, fn_match), ed);
      xfer(1'b0, ridx_addr(k), 0, r, e, w); check("R11 random readback", r, ed);
      ed = $urandom;
      xfer(1'b1, A_CNT, ed, r, e, w);
      if (pm) wait_idle();
      xfer(1'b0, A_CNT, 0, r, e, w); check("R7 random counter", r, ed);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule